// File: doc/BRIEF.md
# Graphics DRAM Command Decoder

This block sits at the command input of a two-bank synchronous graphics DRAM model or controller front end. On every rising clock edge it samples chip select, the row and column strobes, write enable and the graphics-function pin, and turns them into one command. The graphics-function pin turns three plain DRAM opcodes into graphics variants: loading the special registers, opening a row with per-bit write masking, and block write. The block keeps the mode word, the two fill colours and the per-bit write mask, and it knows which banks have an open row.

Every accepted command appears one cycle after its edge as a single set bit on a one-hot output, together with the bank, row, column and auto-precharge fields, the write mask and the fill colour that apply to it. A command that breaks a sequencing rule or carries a reserved opcode sets the illegal flag instead and changes no state. Downstream data-path and timing logic consume these outputs.

Top module: `sgram_cmd_decoder`

## Requirements
- R1: With cs_n low, {ras_n,cas_n,we_n} selects the command and is reported on cmd_onehot one cycle after the sampling edge at these bit positions: 111 no-op (bit 0); 000 mode load (bit 1), or special load when dsf=1 (bit 2); 011 activate (bit 3), or activate with per-bit mask when dsf=1 (bit 4); 101 read (bit 5); 100 write (bit 6), or block write when dsf=1 (bit 7); 110 burst stop (bit 8); 010 precharge (bit 9); 001 refresh (bit 10). An activate reports its row on cmd_row and its bank on cmd_bank.
- R2: With cs_n high, cmd_onehot is zero, illegal stays low and no mode, register or bank state changes, whatever the other pins carry.
- R3: After reset mode_word is 0x020. A legal mode load copies addr[9:0] into mode_word, whose fields are burst length addr[2:0], interleave addr[3], read latency addr[6:4], two-colour mode addr[7] and write mode addr[9:8].
- R4: A mode load is illegal and leaves mode_word unchanged if the burst-length code is 100, 101 or 110, if it is 111 with addr[3]=1, if the latency code is other than 010 or 011, or if addr[9]=1.
- R5: A mode load or refresh while any bank is open is illegal.
- R6: Any command other than no-op issued on the edge directly after a legal mode load is illegal; the edge after that is free again.
- R7: A special load with addr[9:8]=0 and addr[4:0]=0 loads dq into wpb_mask when addr[7:5]=001, into color0 when addr[7:5]=010, and when addr[7:5]=110 into color1 in two-colour mode or into color0 otherwise.
- R8: Any other special-load address pattern, including bit 5 together with bit 6 or 7, or bit 7 alone, is illegal and loads nothing.
- R9: Activating an open bank, or reading, writing or block writing an idle bank, is illegal. An illegal command gives cmd_onehot zero and illegal high, and leaves bank_open and mode_word unchanged.
- R10: A precharge with addr[8]=1 closes every bank whatever ba holds; with addr[8]=0 it closes only bank ba.
- R11: A read, write or block write with addr[8]=1 reports cmd_autopre=1 and leaves its bank idle, except when the burst-length code is 111 (full page), where cmd_autopre is 0 and the bank stays open. cmd_col carries addr[7:0].
- R12: A write or block write to a bank opened with the per-bit mask reports cmd_wmask = wpb_mask, otherwise all ones. A block write reports cmd_col with its low three bits cleared, and cmd_fill = color1 when two-colour mode is set and addr[0]=1, else color0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all pins sampled on the rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| cs_n | input | 1 | Chip select, low enables decoding |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write enable |
| dsf | input | 1 | Graphics-function select |
| ba | input | BA_W | Bank select |
| addr | input | ROW_W | Row, column or opcode bits |
| dq | input | DATA_W | Data for special-register loads |
| cmd_onehot | output | 11 | Accepted command, one bit per kind |
| illegal | output | 1 | Previous command was rejected |
| cmd_bank | output | BA_W | Bank of the last accepted command |
| cmd_row | output | ROW_W | Row of the last accepted command |
| cmd_col | output | COL_W | Column of the last accepted command |
| cmd_autopre | output | 1 | Auto-precharge takes effect |
| cmd_wmask | output | DATA_W | Per-bit write mask in force |
| cmd_fill | output | DATA_W | Fill colour for a block write |
| bank_open | output | NBANKS | One bit per bank, high when a row is open |
| mode_word | output | 10 | Current mode register |
| color0 | output | DATA_W | First fill colour |
| color1 | output | DATA_W | Second fill colour |
| wpb_mask | output | DATA_W | Per-bit write mask register |

## Verification
The hardest state to reach is the one where several conditions must line up on consecutive edges: a mode load immediately followed by another command, or a write with auto-precharge requested while the full-page burst code is active and the target bank was opened with the per-bit mask. The stimulus reaches these by driving commands back to back with no idle cycle between them, first closing every bank so the mode load is accepted, then loading the full-page code with two-colour mode, loading mask and colours, and only then opening the masked bank and issuing the write and block writes against it.

// File: rtl/sgcmd_pkg.sv
package sgcmd_pkg;

  localparam int NCMD = 11;
  localparam logic [9:0] MODE_RST = 10'h020;

  typedef enum logic [3:0] {
    K_NOP   = 4'd0,
    K_LMR   = 4'd1,
    K_LSMR  = 4'd2,
    K_ACT   = 4'd3,
    K_ACTM  = 4'd4,
    K_RD    = 4'd5,
    K_WR    = 4'd6,
    K_BW    = 4'd7,
    K_BST   = 4'd8,
    K_PRE   = 4'd9,
    K_REF   = 4'd10,
    K_DESEL = 4'd15
  } cmd_kind_e;

  typedef enum logic [1:0] {
    SL_BAD  = 2'd0,
    SL_MASK = 2'd1,
    SL_C0   = 2'd2,
    SL_C1   = 2'd3
  } sl_tgt_e;

  // True when an opcode holds no reserved field value.
  function automatic logic mode_ok(input logic [9:0] op);
    logic bl_ok, cl_ok;
    bl_ok = (op[2:0] <= 3'b011) || (op[2:0] == 3'b111 && !op[3]);
    cl_ok = (op[6:4] == 3'b010) || (op[6:4] == 3'b011);
    return bl_ok && cl_ok && !op[9];
  endfunction

  // Which special register an opcode addresses.
  function automatic sl_tgt_e sl_target(input logic [9:0] op, input logic two_color);
    sl_tgt_e t;
    t = SL_BAD;
    if (op[9:8] == 2'b00 && op[4:0] == 5'b00000) begin
      case (op[7:5])
        3'b001:  t = SL_MASK;
        3'b010:  t = SL_C0;
        3'b110:  t = two_color ? SL_C1 : SL_C0;
        default: t = SL_BAD;
      endcase
    end
    return t;
  endfunction

endpackage

// File: rtl/sgcmd_decode.sv
module sgcmd_decode
  import sgcmd_pkg::*;
(
  input  logic      cs_n,
  input  logic      ras_n,
  input  logic      cas_n,
  input  logic      we_n,
  input  logic      dsf,
  output cmd_kind_e kind
);

  always_comb begin
    kind = K_DESEL;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b111:  kind = K_NOP;
        3'b000:  kind = dsf ? K_LSMR : K_LMR;
        3'b011:  kind = dsf ? K_ACTM : K_ACT;
        3'b101:  kind = K_RD;
        3'b100:  kind = dsf ? K_BW : K_WR;
        3'b110:  kind = K_BST;
        3'b010:  kind = K_PRE;
        default: kind = K_REF;
      endcase
    end
  end

endmodule

// File: rtl/sgcmd_mode_regs.sv
module sgcmd_mode_regs
  import sgcmd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MRD    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lmr_we,
  input  logic [9:0]        op,
  input  logic              sl_we,
  input  sl_tgt_e           sl_tgt,
  input  logic [DATA_W-1:0] dq,
  output logic [9:0]        mode_q,
  output logic [DATA_W-1:0] color0_q,
  output logic [DATA_W-1:0] color1_q,
  output logic [DATA_W-1:0] mask_q,
  output logic              mrd_busy
);

  localparam int CW = (MRD > 1) ? $clog2(MRD + 1) : 1;
  localparam logic [CW-1:0] LOAD_V = (MRD > 1) ? CW'(MRD - 1) : '0;

  logic [9:0]        mode_d;
  logic [DATA_W-1:0] color0_d, color1_d, mask_d;
  logic [CW-1:0]     cnt_q, cnt_d;

  always_comb begin
    mode_d   = mode_q;
    color0_d = color0_q;
    color1_d = color1_q;
    mask_d   = mask_q;
    if (lmr_we) mode_d = op;
    if (sl_we) begin
      case (sl_tgt)
        SL_MASK: mask_d   = dq;
        SL_C0:   color0_d = dq;
        SL_C1:   color1_d = dq;
        default: ;
      endcase
    end
    if (lmr_we)          cnt_d = LOAD_V;
    else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
    else                 cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_RST;
      color0_q <= '0;
      color1_q <= '0;
      mask_q   <= '0;
      cnt_q    <= '0;
    end else begin
      mode_q   <= mode_d;
      color0_q <= color0_d;
      color1_q <= color1_d;
      mask_q   <= mask_d;
      cnt_q    <= cnt_d;
    end
  end

  assign mrd_busy = (cnt_q != 0);

  // Only supported latency codes ever reach the register.
  assert_mode_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[6:4] == 3'b010) || (mode_q[6:4] == 3'b011));

  // A load always targets a real register.
  assert_sl_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sl_we |-> sl_tgt != SL_BAD);

  generate
    if (MRD > 1) begin : g_mrd_chk
      assert_mrd_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lmr_we |=> mrd_busy);
    end
  endgenerate

endmodule

// File: rtl/sgcmd_bank_track.sv
module sgcmd_bank_track #(
  parameter int NBANKS = 2,
  parameter int BA_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_en,
  input  logic              act_wpb,
  input  logic [BA_W-1:0]   act_bank,
  input  logic [NBANKS-1:0] close_mask,
  output logic [NBANKS-1:0] open_q,
  output logic [NBANKS-1:0] wpb_q
);

  generate
    for (genvar i = 0; i < NBANKS; i++) begin : g_bank
      logic open_d, wpb_d, hit;

      always_comb begin
        hit    = act_en && (int'(act_bank) == i);
        open_d = open_q[i];
        wpb_d  = wpb_q[i];
        if (close_mask[i]) begin
          open_d = 1'b0;
          wpb_d  = 1'b0;
        end else if (hit) begin
          open_d = 1'b1;
          wpb_d  = act_wpb;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          open_q[i] <= 1'b0;
          wpb_q[i]  <= 1'b0;
        end else begin
          open_q[i] <= open_d;
          wpb_q[i]  <= wpb_d;
        end
      end

      assert_close_R10: assert property (@(posedge clk) disable iff (!rst_n)
        close_mask[i] |=> !open_q[i]);
    end
  endgenerate

  // Activation is only ever requested for an idle bank.
  assert_act_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    act_en |-> !open_q[act_bank]);

endmodule

// File: rtl/sgram_cmd_decoder.sv
module sgram_cmd_decoder
  import sgcmd_pkg::*;
#(
  parameter int NBANKS = 2,
  parameter int ROW_W  = 10,
  parameter int COL_W  = 8,
  parameter int DATA_W = 32,
  parameter int MRD    = 2,
  localparam int BA_W  = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              dsf,
  input  logic [BA_W-1:0]   ba,
  input  logic [ROW_W-1:0]  addr,
  input  logic [DATA_W-1:0] dq,
  output logic [NCMD-1:0]   cmd_onehot,
  output logic              illegal,
  output logic [BA_W-1:0]   cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic              cmd_autopre,
  output logic [DATA_W-1:0] cmd_wmask,
  output logic [DATA_W-1:0] cmd_fill,
  output logic [NBANKS-1:0] bank_open,
  output logic [9:0]        mode_word,
  output logic [DATA_W-1:0] color0,
  output logic [DATA_W-1:0] color1,
  output logic [DATA_W-1:0] wpb_mask
);

  cmd_kind_e         kind;
  sl_tgt_e           sl_tgt;
  logic [NBANKS-1:0] open_q, wpb_q, close_mask;
  logic [9:0]        mode_q;
  logic [DATA_W-1:0] color0_q, color1_q, mask_q;
  logic              mrd_busy;
  logic              legal, fire, is_rw, full_page, ap_req;
  logic              lmr_we, sl_we, act_en, act_wpb;

  logic [NCMD-1:0]   oh_q, oh_d;
  logic              ill_q, ill_d;
  logic [BA_W-1:0]   bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q, col_d;
  logic              ap_q, ap_d;
  logic [DATA_W-1:0] wmask_q, wmask_d, fill_q, fill_d;

  sgcmd_decode i_decode (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .dsf   (dsf),
    .kind  (kind)
  );

  sgcmd_mode_regs #(.DATA_W(DATA_W), .MRD(MRD)) i_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .lmr_we   (lmr_we),
    .op       (addr[9:0]),
    .sl_we    (sl_we),
    .sl_tgt   (sl_tgt),
    .dq       (dq),
    .mode_q   (mode_q),
    .color0_q (color0_q),
    .color1_q (color1_q),
    .mask_q   (mask_q),
    .mrd_busy (mrd_busy)
  );

  sgcmd_bank_track #(.NBANKS(NBANKS), .BA_W(BA_W)) i_banks (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_en     (act_en),
    .act_wpb    (act_wpb),
    .act_bank   (ba),
    .close_mask (close_mask),
    .open_q     (open_q),
    .wpb_q      (wpb_q)
  );

  // Legality of the sampled command against current state.
  always_comb begin
    sl_tgt    = sl_target(addr[9:0], mode_q[7]);
    full_page = (mode_q[2:0] == 3'b111);
    ap_req    = addr[8] && !full_page;
    is_rw     = (kind == K_RD) || (kind == K_WR) || (kind == K_BW);
    case (kind)
      K_LMR:             legal = !(|open_q) && mode_ok(addr[9:0]);
      K_REF:             legal = !(|open_q);
      K_LSMR:            legal = (sl_tgt != SL_BAD);
      K_ACT, K_ACTM:     legal = !open_q[ba];
      K_RD, K_WR, K_BW:  legal = open_q[ba];
      default:           legal = 1'b1;
    endcase
    if (mrd_busy && kind != K_NOP && kind != K_DESEL) legal = 1'b0;
    fire = legal && (kind != K_DESEL);
  end

  // State strobes.
  always_comb begin
    lmr_we  = fire && (kind == K_LMR);
    sl_we   = fire && (kind == K_LSMR);
    act_en  = fire && ((kind == K_ACT) || (kind == K_ACTM));
    act_wpb = (kind == K_ACTM);
    close_mask = '0;
    for (int i = 0; i < NBANKS; i++) begin
      if (fire && kind == K_PRE && (addr[8] || int'(ba) == i)) close_mask[i] = 1'b1;
      if (fire && is_rw && ap_req && int'(ba) == i)            close_mask[i] = 1'b1;
    end
  end

  // Output field next-state.
  always_comb begin
    oh_d    = fire ? (NCMD'(1) << kind) : '0;
    ill_d   = !legal;
    col_d   = (kind == K_BW) ? {addr[COL_W-1:3], 3'b000} : addr[COL_W-1:0];
    ap_d    = is_rw && ap_req;
    wmask_d = wpb_q[ba] ? mask_q : '1;
    fill_d  = (mode_q[7] && addr[0]) ? color1_q : color0_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oh_q    <= '0;
      ill_q   <= 1'b0;
      bank_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      ap_q    <= 1'b0;
      wmask_q <= '0;
      fill_q  <= '0;
    end else begin
      oh_q  <= oh_d;
      ill_q <= ill_d;
      if (fire) begin
        bank_q  <= ba;
        row_q   <= addr;
        col_q   <= col_d;
        ap_q    <= ap_d;
        wmask_q <= wmask_d;
        fill_q  <= fill_d;
      end
    end
  end

  assign cmd_onehot  = oh_q;
  assign illegal     = ill_q;
  assign cmd_bank    = bank_q;
  assign cmd_row     = row_q;
  assign cmd_col     = col_q;
  assign cmd_autopre = ap_q;
  assign cmd_wmask   = wmask_q;
  assign cmd_fill    = fill_q;
  assign bank_open   = open_q;
  assign mode_word   = mode_q;
  assign color0      = color0_q;
  assign color1      = color1_q;
  assign wpb_mask    = mask_q;

  assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_onehot));

  assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (cmd_onehot == '0) && (bank_open == $past(bank_open))
                && (mode_word == $past(mode_word)));

  assert_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (cmd_onehot == '0) && !illegal);

  assert_autopre_closes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_autopre && (cmd_onehot != '0) |-> !bank_open[cmd_bank]);

endmodule

// File: tb/test_sgram_cmd_decoder.sv
module test_sgram_cmd_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 27;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, ras_n, cas_n, we_n, dsf;
  logic [0:0]  ba;
  logic [9:0]  addr;
  logic [31:0] dq;
  logic [10:0] cmd_onehot;
  logic        illegal;
  logic [0:0]  cmd_bank;
  logic [9:0]  cmd_row;
  logic [7:0]  cmd_col;
  logic        cmd_autopre;
  logic [31:0] cmd_wmask, cmd_fill, color0, color1, wpb_mask;
  logic [1:0]  bank_open;
  logic [9:0]  mode_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgram_cmd_decoder i_sgram_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .dsf(dsf), .ba(ba), .addr(addr), .dq(dq),
    .cmd_onehot(cmd_onehot), .illegal(illegal), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_autopre(cmd_autopre),
    .cmd_wmask(cmd_wmask), .cmd_fill(cmd_fill), .bank_open(bank_open),
    .mode_word(mode_word), .color0(color0), .color1(color1), .wpb_mask(wpb_mask)
  );

  // Entry: cs_n, {ras,cas,we}, dsf, ba, addr, expected onehot, expected illegal, requirement
  localparam logic [31:0] VEC [NV] = '{
    {1'b0, 3'b111, 1'b0, 1'b0, 10'h000, 11'h001, 1'b0, 4'd1},  // R1 no-op
    {1'b1, 3'b000, 1'b0, 1'b0, 10'h000, 11'h000, 1'b0, 4'd2},  // R2 deselect
    {1'b0, 3'b101, 1'b0, 1'b0, 10'h005, 11'h000, 1'b1, 4'd9},  // R9 read idle bank
    {1'b0, 3'b011, 1'b0, 1'b0, 10'h155, 11'h008, 1'b0, 4'd1},  // R1 activate
    {1'b0, 3'b011, 1'b1, 1'b0, 10'h155, 11'h000, 1'b1, 4'd9},  // R9 reopen
    {1'b0, 3'b000, 1'b0, 1'b0, 10'h0B3, 11'h000, 1'b1, 4'd5},  // R5 mode load open
    {1'b0, 3'b001, 1'b0, 1'b0, 10'h000, 11'h000, 1'b1, 4'd5},  // R5 refresh open
    {1'b0, 3'b011, 1'b1, 1'b1, 10'h2AA, 11'h010, 1'b0, 4'd1},  // R1 masked activate
    {1'b0, 3'b100, 1'b0, 1'b1, 10'h012, 11'h040, 1'b0, 4'd1},  // R1 write
    {1'b0, 3'b110, 1'b0, 1'b0, 10'h000, 11'h100, 1'b0, 4'd1},  // R1 burst stop
    {1'b0, 3'b010, 1'b0, 1'b0, 10'h100, 11'h200, 1'b0, 4'd10}, // R10 close all
    {1'b0, 3'b001, 1'b0, 1'b0, 10'h000, 11'h400, 1'b0, 4'd1},  // R1 refresh
    {1'b0, 3'b000, 1'b0, 1'b0, 10'h0B3, 11'h002, 1'b0, 4'd3},  // R3 mode load
    {1'b0, 3'b111, 1'b0, 1'b0, 10'h000, 11'h001, 1'b0, 4'd6},  // R6 no-op allowed
    {1'b0, 3'b000, 1'b0, 1'b0, 10'h0B3, 11'h002, 1'b0, 4'd3},  // R3 mode load
    {1'b0, 3'b011, 1'b0, 1'b0, 10'h000, 11'h000, 1'b1, 4'd6},  // R6 too soon
    {1'b0, 3'b011, 1'b0, 1'b0, 10'h000, 11'h008, 1'b0, 4'd6},  // R6 window over
    {1'b0, 3'b000, 1'b1, 1'b0, 10'h020, 11'h004, 1'b0, 4'd7},  // R7 mask load
    {1'b0, 3'b000, 1'b1, 1'b0, 10'h060, 11'h000, 1'b1, 4'd8},  // R8 bits 5+6
    {1'b0, 3'b101, 1'b0, 1'b0, 10'h005, 11'h020, 1'b0, 4'd1},  // R1 read
    {1'b0, 3'b100, 1'b1, 1'b0, 10'h008, 11'h080, 1'b0, 4'd1},  // R1 block write
    {1'b0, 3'b010, 1'b0, 1'b0, 10'h000, 11'h200, 1'b0, 4'd10}, // R10 close bank 0
    {1'b0, 3'b101, 1'b0, 1'b0, 10'h005, 11'h000, 1'b1, 4'd9},  // R9 read closed
    {1'b0, 3'b000, 1'b0, 1'b0, 10'h040, 11'h000, 1'b1, 4'd4},  // R4 bad latency
    {1'b0, 3'b000, 1'b0, 1'b0, 10'h02F, 11'h000, 1'b1, 4'd4},  // R4 interleave full page
    {1'b0, 3'b000, 1'b0, 1'b0, 10'h220, 11'h000, 1'b1, 4'd4},  // R4 write mode 1x
    {1'b0, 3'b000, 1'b0, 1'b0, 10'h120, 11'h002, 1'b0, 4'd3}   // R3 single-write mode
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the command edge.
  task automatic issue(input logic c, input logic [2:0] rcw, input logic d,
                       input logic b, input logic [9:0] a, input logic [31:0] data);
    cs_n = c; {ras_n, cas_n, we_n} = rcw; dsf = d; ba = b; addr = a; dq = data;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; dsf = 1'b0; ba = 1'b0; addr = '0; dq = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; dsf = 1'b0; ba = 1'b0; addr = '0; dq = '0;
    @(negedge clk);
    do_reset();

    // Reset state (R3)
    chk("R3 reset onehot", {21'b0, cmd_onehot}, 32'h0);
    chk("R3 reset illegal", {31'b0, illegal}, 32'h0);
    chk("R3 reset banks", {30'b0, bank_open}, 32'h0);
    chk("R3 reset mode", {22'b0, mode_word}, 32'h020);
    chk("R3 reset color0", color0, 32'h0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      issue(v[31], v[30:28], v[27], v[26], v[25:16], 32'h0);
      chk($sformatf("R%0d table %0d", v[3:0], i),
          {20'b0, illegal, cmd_onehot}, {20'b0, v[4], v[15:5]});
    end
    chk("R3 mode after table", {22'b0, mode_word}, 32'h120);
    chk("R10 banks after table", {30'b0, bank_open}, 32'h0);

    // Special registers
    do_reset();
    issue(0, 3'b000, 1, 0, 10'h020, 32'hF0F0_1234);
    chk("R7 mask load", wpb_mask, 32'hF0F0_1234);
    issue(0, 3'b000, 1, 0, 10'h040, 32'hAAAA_5555);
    chk("R7 color0 load", color0, 32'hAAAA_5555);
    issue(0, 3'b000, 1, 0, 10'h0C0, 32'h1111_2222);
    chk("R7 one-colour bit7 ignored c0", color0, 32'h1111_2222);
    chk("R7 one-colour c1 untouched", color1, 32'h0);
    issue(0, 3'b000, 1, 0, 10'h080, 32'hFFFF_FFFF);
    chk("R8 bit7 alone illegal", {31'b0, illegal}, 32'h1);
    chk("R8 colors kept", color0 ^ color1, 32'h1111_2222);
    issue(0, 3'b000, 1, 0, 10'h021, 32'hFFFF_FFFF);
    chk("R8 stray bit illegal", {31'b0, illegal}, 32'h1);
    chk("R8 mask kept", wpb_mask, 32'hF0F0_1234);

    issue(0, 3'b000, 0, 0, 10'h0A7, 32'h0);
    chk("R3 full page two-colour mode", {22'b0, mode_word}, 32'h0A7);
    issue(0, 3'b111, 0, 0, 10'h000, 32'h0);
    issue(0, 3'b000, 1, 0, 10'h0C0, 32'h3333_4444);
    chk("R7 color1 load", color1, 32'h3333_4444);
    chk("R7 color0 kept", color0, 32'h1111_2222);

    // Masked bank, full page, block write
    issue(0, 3'b011, 1, 1, 10'h3FF, 32'h0);
    chk("R1 activate row", {22'b0, cmd_row}, 32'h3FF);
    chk("R1 activate bank", {31'b0, cmd_bank}, 32'h1);
    chk("R1 bank open", {30'b0, bank_open}, 32'h2);
    issue(0, 3'b100, 0, 1, 10'h15A, 32'h0);
    chk("R11 full page ignores autopre", {31'b0, cmd_autopre}, 32'h0);
    chk("R11 bank stays open", {30'b0, bank_open}, 32'h2);
    chk("R11 write column", {24'b0, cmd_col}, 32'h5A);
    chk("R12 masked write mask", cmd_wmask, 32'hF0F0_1234);
    issue(0, 3'b100, 1, 1, 10'h05D, 32'h0);
    chk("R12 block column aligned", {24'b0, cmd_col}, 32'h58);
    chk("R12 fill color1", cmd_fill, 32'h3333_4444);
    chk("R12 block onehot", {21'b0, cmd_onehot}, 32'h080);
    issue(0, 3'b100, 1, 1, 10'h05C, 32'h0);
    chk("R12 fill color0", cmd_fill, 32'h1111_2222);
    issue(0, 3'b011, 0, 0, 10'h000, 32'h0);
    issue(0, 3'b100, 0, 0, 10'h001, 32'h0);
    chk("R12 unmasked write", cmd_wmask, 32'hFFFF_FFFF);

    // Deselect leaves everything alone
    issue(1, 3'b000, 0, 0, 10'h023, 32'hDEAD_BEEF);
    chk("R2 deselect onehot", {20'b0, illegal, cmd_onehot}, 32'h0);
    chk("R2 deselect mode kept", {22'b0, mode_word}, 32'h0A7);
    chk("R2 deselect banks kept", {30'b0, bank_open}, 32'h3);

    // Precharge variants
    issue(0, 3'b010, 0, 1, 10'h000, 32'h0);
    chk("R10 single bank close", {30'b0, bank_open}, 32'h1);
    issue(0, 3'b011, 0, 1, 10'h000, 32'h0);
    issue(0, 3'b010, 0, 0, 10'h100, 32'h0);
    chk("R10 all banks close", {30'b0, bank_open}, 32'h0);

    // Auto-precharge with fixed burst
    issue(0, 3'b000, 0, 0, 10'h023, 32'h0);
    issue(0, 3'b111, 0, 0, 10'h000, 32'h0);
    issue(0, 3'b011, 0, 0, 10'h000, 32'h0);
    issue(0, 3'b101, 0, 0, 10'h107, 32'h0);
    chk("R11 autopre reported", {31'b0, cmd_autopre}, 32'h1);
    chk("R11 bank closed", {30'b0, bank_open}, 32'h0);
    chk("R11 read column", {24'b0, cmd_col}, 32'h07);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule